// File: doc/BRIEF.md
# Priority Memory Chip-Select Decoder

This block turns a microcontroller address into one active-high select for the memory or register region that owns that address. There are seven windows: four boot-ROM blocks, one scratch RAM, one internal register window and one peripheral window. Each window has an enable, a power-of-two size and a base. All of them are held in registers that software or boot logic loads through a one-cycle write port after reset. The address-to-select path is purely combinational. It reads the registered configuration, so a new address is decoded in the same cycle.

RAM and the two I/O windows may be placed on top of ROM. Where they overlap, they win and the shadowed ROM bytes cannot be reached. ROM blocks may never overlap each other, and the RAM and I/O windows may never overlap each other. A rule checker watches the stored configuration. While any rule is broken, it raises an error flag and silences every select. A 3-bit hit code reports which region claimed the current address.

ROM block size follows from a density parameter (256, 512 or 1024 Kbit split into four equal blocks). RAM capacity is 16 Kbit. Both are counted in bus words, so an 8-bit bus gives 8 KB ROM blocks and 2K RAM words.

Top module: `csd_decoder`

## Requirements
- R1: After reset every window is disabled and peripheral mode is off, so no select is active, `hit` is 0 and `cfg_err` is 0.
- R2: An address inside enabled ROM window i (from base up to base + 2^size − 1), with no higher-priority claim, asserts `rom_cs[i]` only.
- R3: A ROM window with size above log2 of the ROM block word count (13 at the default density and bus width) raises `cfg_err`.
- R4: Two enabled ROM windows that share any address raise `cfg_err`, including windows of different sizes.
- R5: Any two enabled windows among RAM, internal I/O and peripheral I/O that share an address raise `cfg_err`.
- R6: RAM, internal I/O or peripheral I/O that claims an address forces all ROM selects low there. The fixed order is RAM, then internal I/O, then peripheral, then ROM 0 to 3.
- R7: A RAM window with size above log2 of the RAM word count (11 for an 8-bit bus) raises `cfg_err`.
- R8: The peripheral window asserts `per_cs` only while the peripheral-mode bit is 1.
- R9: A base with any nonzero bit below its size, or a size above `ADDR_W`, raises `cfg_err` for that enabled window.
- R10: At most one select is active at a time. While `cfg_err` is 1, every select and `hit` are 0.
- R11: `hit` codes are 0 for none, 1 to 4 for ROM 0 to 3, 5 for RAM, 6 for internal I/O and 7 for peripheral, and they always agree with the select outputs.
- R12: A write with `cfg_we` high takes effect from the next rising edge. `cfg_region` values 0 to 3 address ROM blocks, 4 RAM, 5 internal I/O and 6 peripheral, each taking `cfg_en`, `cfg_size` and `cfg_base`. Value 7 stores `cfg_en` as the peripheral-mode bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_region | input | 3 | Window index (0 to 6) or 7 for the mode bit |
| cfg_en | input | 1 | Window enable, or the peripheral-mode bit for index 7 |
| cfg_size | input | 5 | log2 of the window size in bus words |
| cfg_base | input | ADDR_W | Window base address |
| addr | input | ADDR_W | Bus address to decode |
| rom_cs | output | 4 | ROM block selects |
| ram_cs | output | 1 | Scratch RAM select |
| io_cs | output | 1 | Internal register window select |
| per_cs | output | 1 | Peripheral window select |
| hit | output | 3 | Code of the region that claimed the address |
| cfg_err | output | 1 | Configuration breaks a window rule |

## Verification
On every clock, the assertions check the following:
- At most one select is active.
- The error flag silences all selects.
- The hit code matches the selects.
- A ROM select never appears where RAM or internal I/O matched, or outside its own window.
- The peripheral select appears only in peripheral mode.

Whether a given window placement is judged legal or illegal is shown only by the bench's scenarios. These cover oversize, overlapping and misaligned windows. The full address-space sweeps show exactly which addresses each select covers, and show that the shadowed ROM regions are unreachable.

// File: rtl/csd_pkg.sv
`timescale 1ns/1ps
package csd_pkg;
  localparam int NWIN     = 7;
  localparam int NROM     = 4;
  localparam int IDX_RAM  = 4;
  localparam int IDX_IO   = 5;
  localparam int IDX_PER  = 6;
  localparam int IDX_MODE = 7;

  typedef enum logic [2:0] {
    HIT_NONE = 3'd0,
    HIT_ROM0 = 3'd1,
    HIT_ROM1 = 3'd2,
    HIT_ROM2 = 3'd3,
    HIT_ROM3 = 3'd4,
    HIT_RAM  = 3'd5,
    HIT_IO   = 3'd6,
    HIT_PER  = 3'd7
  } hit_e;
endpackage

// File: rtl/csd_cfg_regs.sv
`timescale 1ns/1ps
module csd_cfg_regs
  import csd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SZ_W   = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_we,
  input  logic [2:0]                    cfg_region,
  input  logic                          cfg_en,
  input  logic [SZ_W-1:0]               cfg_size,
  input  logic [ADDR_W-1:0]             cfg_base,
  output logic [NWIN-1:0]               win_en,
  output logic [NWIN-1:0][SZ_W-1:0]     win_size,
  output logic [NWIN-1:0][ADDR_W-1:0]   win_base,
  output logic                          per_mode
);
  logic [1:0] rs_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  logic [NWIN-1:0]             en_q, en_d;
  logic [NWIN-1:0][SZ_W-1:0]   size_q, size_d;
  logic [NWIN-1:0][ADDR_W-1:0] base_q, base_d;
  logic                        mode_q, mode_d;
  logic                        wr_win, wr_mode;

  assign wr_mode = cfg_we && (cfg_region == 3'(IDX_MODE));
  assign wr_win  = cfg_we && (cfg_region != 3'(IDX_MODE));

  always_comb begin
    en_d   = en_q;
    size_d = size_q;
    base_d = base_q;
    mode_d = mode_q;
    if (wr_mode) mode_d = cfg_en;
    for (int i = 0; i < NWIN; i++) begin
      if (wr_win && (cfg_region == 3'(i))) begin
        en_d[i]   = cfg_en;
        size_d[i] = cfg_size;
        base_d[i] = cfg_base;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      en_q   <= '0;
      size_q <= '0;
      base_q <= '0;
      mode_q <= 1'b0;
    end else if (cfg_we) begin
      en_q   <= en_d;
      size_q <= size_d;
      base_q <= base_d;
      mode_q <= mode_d;
    end
  end

  assign win_en   = en_q;
  assign win_size = size_q;
  assign win_base = base_q;
  assign per_mode = mode_q;
endmodule

// File: rtl/csd_window_match.sv
`timescale 1ns/1ps
module csd_window_match
  import csd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SZ_W   = 5
) (
  input  logic [ADDR_W-1:0]             addr,
  input  logic [NWIN-1:0]               win_en,
  input  logic [NWIN-1:0][SZ_W-1:0]     win_size,
  input  logic [NWIN-1:0][ADDR_W-1:0]   win_base,
  output logic [NWIN-1:0]               win_hit
);
  localparam logic [ADDR_W-1:0] ONE = 1;

  function automatic logic [ADDR_W-1:0] low_mask(input logic [SZ_W-1:0] k);
    logic [ADDR_W:0] sh;
    sh = {{ADDR_W{1'b0}}, 1'b1} << k;
    return sh[ADDR_W-1:0] - ONE;
  endfunction

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    logic [ADDR_W-1:0] diff;
    assign diff       = (addr ^ win_base[g]) & ~low_mask(win_size[g]);
    assign win_hit[g] = win_en[g] && (diff == '0);
  end
endmodule

// File: rtl/csd_rule_check.sv
`timescale 1ns/1ps
module csd_rule_check
  import csd_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int SZ_W     = 5,
  parameter int ROM_LOG2 = 13,
  parameter int RAM_LOG2 = 11
) (
  input  logic [NWIN-1:0]               win_en,
  input  logic [NWIN-1:0][SZ_W-1:0]     win_size,
  input  logic [NWIN-1:0][ADDR_W-1:0]   win_base,
  output logic                          cfg_err
);
  localparam logic [ADDR_W-1:0] ONE = 1;

  function automatic logic [ADDR_W-1:0] low_mask(input logic [SZ_W-1:0] k);
    logic [ADDR_W:0] sh;
    sh = {{ADDR_W{1'b0}}, 1'b1} << k;
    return sh[ADDR_W-1:0] - ONE;
  endfunction

  logic [NWIN-1:0]            bad_align;
  logic [NWIN-1:0]            bad_size;
  logic [NWIN-1:0][NWIN-1:0]  clash;

  for (genvar i = 0; i < NWIN; i++) begin : g_one
    logic [SZ_W-1:0] cap;
    if (i < NROM) begin : g_rom_cap
      assign cap = SZ_W'(ROM_LOG2);
    end else if (i == IDX_RAM) begin : g_ram_cap
      assign cap = SZ_W'(RAM_LOG2);
    end else begin : g_io_cap
      assign cap = SZ_W'(ADDR_W);
    end
    assign bad_size[i]  = win_en[i] && ((win_size[i] > cap) || (win_size[i] > SZ_W'(ADDR_W)));
    assign bad_align[i] = win_en[i] && ((win_base[i] & low_mask(win_size[i])) != '0);

    for (genvar j = 0; j < NWIN; j++) begin : g_pair
      if ((j > i) && ((i < NROM) == (j < NROM))) begin : g_chk
        logic [SZ_W-1:0]   kmax;
        logic [ADDR_W-1:0] diff;
        assign kmax = (win_size[i] > win_size[j]) ? win_size[i] : win_size[j];
        assign diff = (win_base[i] ^ win_base[j]) & ~low_mask(kmax);
        assign clash[i][j] = win_en[i] && win_en[j] && (diff == '0);
      end else begin : g_none
        assign clash[i][j] = 1'b0;
      end
    end
  end

  assign cfg_err = (|bad_align) || (|bad_size) || (|clash);
endmodule

// File: rtl/csd_decoder.sv
`timescale 1ns/1ps
module csd_decoder
  import csd_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 8,
  parameter int DENSITY_KBIT = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_region,
  input  logic              cfg_en,
  input  logic [4:0]        cfg_size,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [ADDR_W-1:0] addr,
  output logic [3:0]        rom_cs,
  output logic              ram_cs,
  output logic              io_cs,
  output logic              per_cs,
  output logic [2:0]        hit,
  output logic              cfg_err
);
  localparam int SZ_W      = 5;
  localparam int ROM_WORDS = (DENSITY_KBIT * 1024) / DATA_W;
  localparam int ROM_BLK   = ROM_WORDS / NROM;
  localparam int ROM_LOG2  = $clog2(ROM_BLK);
  localparam int RAM_LOG2  = $clog2(16384 / DATA_W);

  logic [NWIN-1:0]             win_en;
  logic [NWIN-1:0][SZ_W-1:0]   win_size;
  logic [NWIN-1:0][ADDR_W-1:0] win_base;
  logic                        per_mode;
  logic [NWIN-1:0]             win_hit;
  logic                        err;
  hit_e                        hit_n;

  csd_cfg_regs #(.ADDR_W(ADDR_W), .SZ_W(SZ_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_region(cfg_region),
    .cfg_en(cfg_en), .cfg_size(cfg_size), .cfg_base(cfg_base),
    .win_en(win_en), .win_size(win_size), .win_base(win_base), .per_mode(per_mode)
  );

  csd_window_match #(.ADDR_W(ADDR_W), .SZ_W(SZ_W)) u_match (
    .addr(addr), .win_en(win_en), .win_size(win_size), .win_base(win_base),
    .win_hit(win_hit)
  );

  csd_rule_check #(.ADDR_W(ADDR_W), .SZ_W(SZ_W), .ROM_LOG2(ROM_LOG2),
                   .RAM_LOG2(RAM_LOG2)) u_rules (
    .win_en(win_en), .win_size(win_size), .win_base(win_base), .cfg_err(err)
  );

  always_comb begin
    hit_n = HIT_NONE;
    if (!err) begin
      if (win_hit[IDX_RAM])                  hit_n = HIT_RAM;
      else if (win_hit[IDX_IO])              hit_n = HIT_IO;
      else if (win_hit[IDX_PER] && per_mode) hit_n = HIT_PER;
      else begin
        for (int i = NROM - 1; i >= 0; i--) begin
          if (win_hit[i]) hit_n = hit_e'(3'(i + 1));
        end
      end
    end
  end

  for (genvar g = 0; g < NROM; g++) begin : g_rom_sel
    assign rom_cs[g] = (hit_n == hit_e'(3'(g + 1)));
  end
  assign ram_cs  = (hit_n == HIT_RAM);
  assign io_cs   = (hit_n == HIT_IO);
  assign per_cs  = (hit_n == HIT_PER);
  assign hit     = hit_n;
  assign cfg_err = err;
endmodule

// File: rtl/csd_decoder_chk.sv
`timescale 1ns/1ps
module csd_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] rom_cs,
  input logic       ram_cs,
  input logic       io_cs,
  input logic       per_cs,
  input logic [2:0] hit,
  input logic       cfg_err,
  input logic [6:0] win_hit,
  input logic       per_mode
);
  logic [6:0] sel;
  assign sel = {per_cs, io_cs, ram_cs, rom_cs};

  assert_one_select_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));

  assert_err_silences_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (sel == 7'd0 && hit == 3'd0));

  assert_hit_matches_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((hit == 3'd0) == (sel == 7'd0)) && ((hit == 3'd5) == ram_cs) &&
    ((hit == 3'd6) == io_cs) && ((hit == 3'd7) == per_cs));

  assert_ram_io_shadow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (win_hit[4] || win_hit[5]) |-> (rom_cs == 4'd0));

  assert_rom_inside_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_cs & ~win_hit[3:0]) == 4'd0);

  assert_per_needs_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    per_cs |-> per_mode);
endmodule

bind csd_decoder csd_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rom_cs(rom_cs), .ram_cs(ram_cs), .io_cs(io_cs),
  .per_cs(per_cs), .hit(hit), .cfg_err(cfg_err), .win_hit(win_hit),
  .per_mode(per_mode)
);

// File: tb/csd_decoder_test.sv
`timescale 1ns/1ps
module csd_decoder_test;
  localparam int ADDR_W = 16;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cfg_we;
  logic [2:0]        cfg_region;
  logic              cfg_en;
  logic [4:0]        cfg_size;
  logic [ADDR_W-1:0] cfg_base;
  logic [ADDR_W-1:0] addr;
  logic [3:0]        rom_cs;
  logic              ram_cs, io_cs, per_cs, cfg_err;
  logic [2:0]        hit;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  int  cb [7];
  int  ck [7];
  bit  ce [7];
  bit  mode;
  bit  exp_err;

  always #2 clk = ~clk;

  csd_decoder uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_region(cfg_region),
    .cfg_en(cfg_en), .cfg_size(cfg_size), .cfg_base(cfg_base), .addr(addr),
    .rom_cs(rom_cs), .ram_cs(ram_cs), .io_cs(io_cs), .per_cs(per_cs),
    .hit(hit), .cfg_err(cfg_err)
  );

  function automatic bit in_win(int r, int a);
    return ce[r] && (a >= cb[r]) && (a < cb[r] + (1 << ck[r]));
  endfunction

  function automatic int model_hit(int a);
    if (exp_err) return 0;
    if (in_win(4, a)) return 5;
    if (in_win(5, a)) return 6;
    if (mode && in_win(6, a)) return 7;
    for (int i = 0; i < 4; i++) if (in_win(i, a)) return i + 1;
    return 0;
  endfunction

  task automatic check_now(int a, string tag);
    int eh;
    logic [11:0] got, exp;
    logic [3:0] erom;
    eh = model_hit(a);
    erom = (eh >= 1 && eh <= 4) ? (4'b0001 << (eh - 1)) : 4'b0000;
    exp = {exp_err, 3'(eh), erom, eh == 5, eh == 6, eh == 7};
    got = {cfg_err, hit, rom_cs, ram_cs, io_cs, per_cs};
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s addr=%h actual={err,hit,rom,ram,io,per}=%b expected=%b",
               tag, a[15:0], got, exp);
    end
  endtask

  task automatic probe(int a, string tag);
    @(negedge clk);
    #0.25 addr = a[ADDR_W-1:0];
    #0.5 check_now(a, tag);
  endtask

  task automatic sweep(string tag);
    for (int a = 0; a < (1 << ADDR_W); a += 2) begin
      @(negedge clk);
      #0.25 addr = a[ADDR_W-1:0];
      #0.5 check_now(a, tag);
      addr = ADDR_W'(a + 1);
      #0.5 check_now(a + 1, tag);
    end
  endtask

  task automatic wr(int r, bit en, int k, int base);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_region = 3'(r);
    cfg_en = en;
    cfg_size = 5'(k);
    cfg_base = ADDR_W'(base);
    if (r == 7) mode = en;
    else begin ce[r] = en; ck[r] = k; cb[r] = base; end
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic load_a();
    wr(0, 1, 13, 'h0000); wr(1, 1, 13, 'h2000);
    wr(2, 1, 13, 'h4000); wr(3, 1, 13, 'h6000);
    wr(4, 1, 11, 'h2000); wr(5, 1, 8, 'h6800);
    wr(6, 1, 8, 'h8100); wr(7, 0, 0, 0);
  endtask

  task automatic bad_case(int r, int k, int base, string tag);
    int ob, ok2;
    ob = cb[r]; ok2 = ck[r];
    exp_err = 1'b1;
    wr(r, 1, k, base);
    probe('h0000, tag); probe('h2000, tag); probe(base, tag);
    exp_err = 1'b0;
    wr(r, 1, ok2, ob);
    probe('h0000, "R12 restore"); probe('h2000, "R12 restore");
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL R12 watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 7; i++) begin cb[i] = 0; ck[i] = 0; ce[i] = 0; end
    mode = 0; exp_err = 0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_region = '0; cfg_en = 1'b0;
    cfg_size = '0; cfg_base = '0; addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    probe('h0000, "R1"); probe('h2000, "R1"); probe('h8100, "R1");

    // R2 R6 R11 R12: ROM blocks with RAM and IO shadowing, peripheral mode off (R8)
    load_a();
    sweep("R2 R6 R8 R11");
    // R8: peripheral mode on
    wr(7, 1, 0, 0);
    sweep("R8 R6 R11");

    // R3: ROM window of 16K words exceeds the 8K block
    bad_case(2, 14, 'h8000, "R3");
    // R4: identical ROM windows, then different sizes overlapping
    bad_case(1, 13, 'h0000, "R4");
    bad_case(1, 12, 'h1000, "R4");
    // R5: IO inside RAM, peripheral on top of IO
    bad_case(5, 8, 'h2400, "R5");
    bad_case(6, 8, 'h6800, "R5");
    // R7: RAM window of 4K words
    bad_case(4, 12, 'h2000, "R7");
    // R9: misaligned base and size wider than the bus
    bad_case(5, 8, 'h6880, "R9");
    bad_case(6, 17, 'h0000, "R9");
    // R10: error clears and decode resumes
    probe('h2100, "R10"); probe('h6810, "R10");

    // Second placement: mixed sizes, one ROM block disabled, adjacent IO windows
    wr(0, 1, 12, 'hF000); wr(1, 1, 12, 'h1000);
    wr(2, 0, 13, 'h4000); wr(3, 1, 13, 'hA000);
    wr(4, 1, 11, 'hF800); wr(5, 1, 4, 'hA000);
    wr(6, 1, 4, 'hA010);
    sweep("R2 R6 R10 R11");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule